// File: doc/BRIEF.md
# Per-CPU Banked GPIO Interrupt Steering Unit

This unit sits between the pad logic of a GPIO bank and the interrupt inputs of several processors. The pad logic hands it two vectors each cycle: a one-cycle pulse per line when that line has seen an edge, and the current (polarity-corrected) input level of every line. Each CPU gets its own bank of three registers: a latched edge-cause register, an edge-enable mask and a level-enable mask. A given GPIO event can therefore be steered to any subset of processors, and each processor acknowledges it on its own.

An edge pulse sets the matching cause bit in every CPU's cause register at once. A CPU clears its copy by writing a zero to that bit. A line raises a request for a CPU when its latched edge cause is enabled by that CPU's edge mask, or when its input level is high and enabled by that CPU's level mask. Requests are ORed in groups of eight lines, so each CPU gets four group interrupt outputs.

A simple register port with a write strobe and a combinational read reaches all banks. Cause registers sit at byte offset 4·n, edge masks at 0x10 + 4·n and level masks at 0x20 + 4·n, where n is the CPU index.

Top module: `irqbank_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every cause, edge-mask and level-mask register becomes zero, so all reads return zero and irq_out is zero.
- R2: A write to byte offset 0x10 + 4·n loads the edge mask of CPU n, and a write to 0x20 + 4·n loads its level mask. Both read back at the same offset from the cycle after the write.
- R3: An edge pulse on line i in a cycle sets bit i of the cause register of every CPU. This is visible at offset 4·n from the next cycle.
- R4: A write to offset 4·n clears each cause bit of CPU n whose write-data bit is 0 and keeps each bit whose write-data bit is 1. The other CPUs' cause registers are unchanged.
- R5: When an edge pulse and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R6: Line i requests CPU n when level_in[i] and bit i of CPU n's level mask are both 1. This takes effect in the same cycle, with no latching.
- R7: Line i requests CPU n when bit i of CPU n's cause register and bit i of its edge mask are both 1.
- R8: irq_out[4·n + g] is the OR of the requests of lines 8·g to 8·g+7 for CPU n. The CPU index is the major index.
- R9: Offsets 0x30 to 0x3F and offsets whose two low bits are not zero read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_evt | input | 32 | One-cycle edge pulse per GPIO line |
| level_in | input | 32 | Current input level per GPIO line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 16 | Group interrupts, CPU-major, four per CPU |

## Verification
The bench builds the unit with its defaults: 32 lines, four CPUs, groups of eight lines and a 6-bit offset. With these values all three banks are fully populated and the unmapped fourth bank is reachable. The lowest and highest lines, and so the first and last groups, can be driven. An event can be shown to reach all four cause copies while one copy is cleared on its own. The set-versus-clear collision and misaligned offsets are driven as directed steps.

// File: rtl/irqbank_pkg.sv
// Shared definitions for the banked interrupt steering unit.
// Assumes a byte-addressed window of 16-byte banks with one 4-byte word per CPU.
package irqbank_pkg;
    localparam int BANK_BYTES = 16;
    localparam int WORD_BYTES = 4;
    localparam int MAX_CPUS   = BANK_BYTES / WORD_BYTES;

    // Register bank selected by the bank bits of the offset (order fixed by the map)
    typedef enum logic [1:0] {
        BANK_CAUSE = 2'd0,
        BANK_EMASK = 2'd1,
        BANK_LMASK = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;
endpackage

// File: rtl/irqbank_decode.sv
// Offset decoder: splits a byte offset into bank and CPU index and flags
// whether it names an implemented register.
// Assumes ADDR_W >= 6 and NUM_CPUS <= MAX_CPUS.
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_CPUS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_e             bank,
    output logic [1:0]        cpu,
    output logic              hit
);
    // Decode bank, CPU and validity of the offset
    always_comb begin
        bank = bank_e'(addr[5:4]);
        cpu  = addr[3:2];
        hit  = (addr[1:0] == 2'b00)
             && ((addr >> 6) == '0)
             && (bank != BANK_NONE)
             && (int'(cpu) < NUM_CPUS);
    end
endmodule

// File: rtl/irqbank_cpu_slice.sv
// One CPU's register bank: latched edge causes, edge mask, level mask and
// the grouped request outputs.
// Assumes edge_evt is a one-cycle pulse from the pad logic and that
// NUM_LINES is a multiple of GROUP_LINES.
module irqbank_cpu_slice #(
    parameter int NUM_LINES   = 32,
    parameter int GROUP_LINES = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  edge_evt,
    input  logic [NUM_LINES-1:0]  level_in,
    input  logic                  wr_cause,
    input  logic                  wr_emask,
    input  logic                  wr_lmask,
    input  logic [NUM_LINES-1:0]  wdata,
    output logic [NUM_LINES-1:0]  cause_q,
    output logic [NUM_LINES-1:0]  emask_q,
    output logic [NUM_LINES-1:0]  lmask_q,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    logic [NUM_LINES-1:0] line_req;

    // Cause latch: write-zero clears, a new edge always wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else if (wr_cause)
            cause_q <= (cause_q & wdata) | edge_evt;
        else
            cause_q <= cause_q | edge_evt;
    end

    // Mask registers loaded by full-word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emask_q <= '0;
            lmask_q <= '0;
        end else begin
            if (wr_emask) emask_q <= wdata;
            if (wr_lmask) lmask_q <= wdata;
        end
    end

    // Per-line request from level and latched edge paths
    always_comb line_req = (level_in & lmask_q) | (cause_q & emask_q);

    // One OR tree per group of lines
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_irq[g] = |line_req[g*GROUP_LINES +: GROUP_LINES];
    end

    // R3
    edge_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((cause_q & $past(edge_evt)) == $past(edge_evt)));

    // R4
    cause_no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt == '0) |=> ((cause_q & ~$past(cause_q)) == '0));

    // R4
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cause && edge_evt == '0) |=> $stable(cause_q));

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (grp_irq == '0));
endmodule

// File: rtl/irqbank_unit.sv
// Top of the banked interrupt steering unit: decodes the register port,
// replicates one register slice per CPU and packs group requests CPU-major.
// Assumes a single-cycle write strobe and a combinational read.
module irqbank_unit
    import irqbank_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int NUM_CPUS    = 4,
    parameter int GROUP_LINES = 8,
    parameter int ADDR_W      = 6,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_LINES,
    localparam int IRQ_W      = NUM_CPUS * NUM_GROUPS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] edge_evt,
    input  logic [NUM_LINES-1:0] level_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic [IRQ_W-1:0]     irq_out
);
    bank_e      sel_bank;
    logic [1:0] sel_cpu;
    logic       sel_hit;

    logic [NUM_CPUS-1:0][NUM_LINES-1:0] cause_all;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] emask_all;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] lmask_all;

    irqbank_decode #(.ADDR_W(ADDR_W), .NUM_CPUS(NUM_CPUS)) u_dec (
        .addr (bus_addr),
        .bank (sel_bank),
        .cpu  (sel_cpu),
        .hit  (sel_hit)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic this_cpu;
        assign this_cpu = bus_we && sel_hit && (int'(sel_cpu) == c);

        irqbank_cpu_slice #(.NUM_LINES(NUM_LINES), .GROUP_LINES(GROUP_LINES)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_evt (edge_evt),
            .level_in (level_in),
            .wr_cause (this_cpu && sel_bank == BANK_CAUSE),
            .wr_emask (this_cpu && sel_bank == BANK_EMASK),
            .wr_lmask (this_cpu && sel_bank == BANK_LMASK),
            .wdata    (bus_wdata),
            .cause_q  (cause_all[c]),
            .emask_q  (emask_all[c]),
            .lmask_q  (lmask_all[c]),
            .grp_irq  (irq_out[c*NUM_GROUPS +: NUM_GROUPS])
        );
    end

    // Read mux over the addressed bank and CPU
    always_comb begin
        bus_rdata = '0;
        if (sel_hit) begin
            case (sel_bank)
                BANK_CAUSE: bus_rdata = cause_all[sel_cpu];
                BANK_EMASK: bus_rdata = emask_all[sel_cpu];
                BANK_LMASK: bus_rdata = lmask_all[sel_cpu];
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_hit) |-> (bus_rdata == '0));

    // R9
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !sel_hit) |=> ($stable(emask_all) && $stable(lmask_all)));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        (!rst_n) |=> (cause_all == '0 && emask_all == '0 && lmask_all == '0));
endmodule

// File: tb/irqbank_unit_test.sv
module irqbank_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] edge_evt = '0;
    logic [31:0] level_in = '0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqbank_unit uut (
        .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .level_in(level_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] evt;
        logic [31:0] lvl;
        logic [5:0]  caddr;
        logic [31:0] exp_rd;
        logic [15:0] exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h10, 32'h0000_00FF, 32'h0, 32'h0,         6'h10, 32'h0000_00FF, 16'h0000, 4'd2}, // R2
        '{1'b1, 6'h24, 32'h0000_FF00, 32'h0, 32'h0,         6'h24, 32'h0000_FF00, 16'h0000, 4'd2}, // R2
        '{1'b0, 6'h00, 32'h0,         32'h0, 32'h0000_0100, 6'h24, 32'h0000_FF00, 16'h0020, 4'd6}, // R6
        '{1'b0, 6'h00, 32'h0,         32'h1, 32'h0,         6'h00, 32'h0000_0001, 16'h0001, 4'd3}, // R3 R7
        '{1'b0, 6'h00, 32'h0,         32'h0, 32'h0,         6'h0C, 32'h0000_0001, 16'h0001, 4'd3}, // R3
        '{1'b1, 6'h0C, 32'hFFFF_FFFE, 32'h0, 32'h0,         6'h0C, 32'h0000_0000, 16'h0001, 4'd4}, // R4
        '{1'b0, 6'h00, 32'h0,         32'h0, 32'h0,         6'h00, 32'h0000_0001, 16'h0001, 4'd4}, // R4
        '{1'b1, 6'h00, 32'hFFFF_FFFF, 32'h0, 32'h0,         6'h00, 32'h0000_0001, 16'h0001, 4'd4}, // R4
        '{1'b1, 6'h00, 32'h0,         32'h1, 32'h0,         6'h00, 32'h0000_0001, 16'h0001, 4'd5}, // R5
        '{1'b1, 6'h00, 32'h0,         32'h0, 32'h0,         6'h00, 32'h0000_0000, 16'h0000, 4'd4}, // R4
        '{1'b1, 6'h18, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 6'h08, 32'h8000_0001, 16'h0900, 4'd8}, // R8
        '{1'b1, 6'h30, 32'hFFFF_FFFF, 32'h0, 32'h0,         6'h30, 32'h0000_0000, 16'h0900, 4'd9}, // R9
        '{1'b1, 6'h11, 32'h0,         32'h0, 32'h0,         6'h10, 32'h0000_00FF, 16'h0900, 4'd9}, // R9
        '{1'b1, 6'h2C, 32'h00FF_0000, 32'h0, 32'h0001_0000, 6'h2C, 32'h00FF_0000, 16'h4900, 4'd8}  // R8 R6
    };

    task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check32({16'h0, irq_out}, 32'h0, "R1 irq after reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        for (int a = 0; a < 48; a += 4) begin
            bus_addr = a[5:0];
            #1;
            check32(bus_rdata, 32'h0, "R1 register zero after reset");
        end

        // Table walk: apply in one cycle, observe in the following one
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_we    = VECS[i].we;
            bus_addr  = VECS[i].addr;
            bus_wdata = VECS[i].wdata;
            edge_evt  = VECS[i].evt;
            level_in  = VECS[i].lvl;
            @(negedge clk);
            bus_we   = 1'b0;
            edge_evt = '0;
            bus_addr = VECS[i].caddr;
            #1;
            check32(bus_rdata, VECS[i].exp_rd, $sformatf("R%0d vector %0d rdata", VECS[i].req, i));
            check32({16'h0, irq_out}, {16'h0, VECS[i].exp_irq}, $sformatf("R%0d vector %0d irq", VECS[i].req, i));
        end

        // R6: level path follows the input with no latching
        level_in = 32'h0;
        #1;
        check32({16'h0, irq_out}, 32'h0000_0900, "R6 level drop same cycle");

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        level_in = 32'h0001_0000;
        @(negedge clk);
        #1;
        check32({16'h0, irq_out}, 32'h0, "R1 irq after mid-run reset");
        rst_n = 1'b1;
        for (int a = 0; a < 48; a += 4) begin
            bus_addr = a[5:0];
            #1;
            check32(bus_rdata, 32'h0, "R1 register zero after mid-run reset");
        end
        finish_run();
    end
endmodule